// File: doc/BRIEF.md
# In-Place Byte-Serial Stack Incrementer

This block adds one to the 16-bit value on top of a byte-wide stack RAM without popping or pushing. The stack pointer names the next free slot: the high byte of the top item sits at pointer-2 and the low byte at pointer-1. The block reads a slot into a counter register, adds one, and writes the result back to the same slot. The low byte is handled first. The high-byte slot is touched only when the low byte wraps from 0xFF to 0x00. In that case an overflow flag is raised and the same read, load and write steps run once more on the high slot.

In keep mode the two operand bytes are first copied into the two slots above them, one byte at a time. The pointer therefore moves up by two, and only the copy is incremented. In the other mode the original bytes are changed where they are and the pointer does not move. The block drives a single-port synchronous RAM. Each access takes one cycle, and read data arrives one cycle after the address.

Top module: `stk_inc_unit`

## Requirements
- R1: After reset `done_o` and `ram_we_o` are low and `sp_o` is 0.
- R2: Without keep, the byte at pointer-1 becomes its old value plus one (mod 256), and `sp_o` equals the start pointer.
- R3: When the low byte is not 0xFF, the high-byte slot keeps its value, and `done_o` rises 4 cycles after the clock edge that samples `start_i`.
- R4: When the low byte is 0xFF, it becomes 0x00 and the high byte gains one, and `done_o` comes 3 cycles later than in R3. The overflow flag is cleared at every accepted start and rises only on a low-byte wrap.
- R5: The value 0xFFFF becomes 0x0000, and the slots at pointer and pointer-3 are not written.
- R6: With keep, the bytes at pointer-2 and pointer-1 stay unchanged. Copies of them go to pointer and pointer+1, the copy is incremented as in R2 to R4, `sp_o` is the start pointer plus 2, and `done_o` comes 4 cycles later than without keep.
- R7: All slot addresses and `sp_o` wrap modulo 2^PTR_W.
- R8: `start_i` is ignored while an operation is in progress. It starts no second operation, writes no other slot and leaves `sp_o` unchanged.
- R9: `done_o` is a one-cycle pulse in the cycle after the last RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an increment (sampled while idle) |
| keep_i | input | 1 | 1: copy the operand above itself before incrementing |
| sp_i | input | PTR_W | Stack pointer (next free slot) at start |
| ram_addr_o | output | PTR_W | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_we_o | output | 1 | RAM write enable |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the address |
| sp_o | output | PTR_W | Pointer after the operation |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the carry decision. A design that always runs the high pass would change the high byte or report the wrong latency, and one that never runs it would leave 0x01FF as 0x0100. The value 0xFFFF and operands that straddle address 0 check that the carry does not spill into neighbouring slots and that the pointer arithmetic wraps. The keep cases catch a design that increments the original instead of the copy or moves the pointer by the wrong amount. A second start issued mid-operation would show up as an extra done pulse, a changed pointer or writes at the second pointer.

// File: rtl/stk_inc_pkg.sv
package stk_inc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CP_RD,
    ST_CP_WR,
    ST_RD,
    ST_LD,
    ST_WR,
    ST_FIN
  } step_e;

  // byte plus one; bit BYTE_W is the carry out
  function automatic logic [BYTE_W:0] byte_inc(input logic [BYTE_W-1:0] v);
    return {1'b0, v} + {{BYTE_W{1'b0}}, 1'b1};
  endfunction

  // pointer growth applied by an accepted start
  function automatic int unsigned sp_growth(input logic keep);
    return keep ? 2 : 0;
  endfunction
endpackage

// File: rtl/stk_inc_ctrl.sv
module stk_inc_ctrl
  import stk_inc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  keep_i,
  input  logic  wrap_i,
  output step_e step_o,
  output logic  cp_idx_o,
  output logic  hi_pass_o,
  output logic  accept_o,
  output logic  busy_o
);
  step_e step_q, step_d;
  logic  cp_idx_q, hi_pass_q;

  assign accept_o = (step_q == ST_IDLE) && start_i;
  assign busy_o   = (step_q != ST_IDLE);

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE:  if (start_i) step_d = keep_i ? ST_CP_RD : ST_RD;
      ST_CP_RD: step_d = ST_CP_WR;
      ST_CP_WR: step_d = cp_idx_q ? ST_RD : ST_CP_RD;
      ST_RD:    step_d = ST_LD;
      ST_LD:    step_d = ST_WR;
      ST_WR:    step_d = (!hi_pass_q && wrap_i) ? ST_RD : ST_FIN;
      ST_FIN:   step_d = ST_IDLE;
      default:  step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q    <= ST_IDLE;
      cp_idx_q  <= 1'b0;
      hi_pass_q <= 1'b0;
    end else begin
      step_q <= step_d;
      if (accept_o) begin
        cp_idx_q  <= 1'b0;
        hi_pass_q <= 1'b0;
      end else begin
        if (step_q == ST_CP_WR) cp_idx_q <= 1'b1;
        if (step_q == ST_WR && !hi_pass_q && wrap_i) hi_pass_q <= 1'b1;
      end
    end
  end

  assign step_o    = step_q;
  assign cp_idx_o  = cp_idx_q;
  assign hi_pass_o = hi_pass_q;
endmodule

// File: rtl/stk_inc_alu.sv
module stk_inc_alu
  import stk_inc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              commit_i,
  input  logic              hi_pass_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [BYTE_W-1:0] sum_o,
  output logic              wrap_o,
  output logic              ovf_o
);
  logic [BYTE_W-1:0] cnt_q;
  logic              ovf_q;
  logic [BYTE_W:0]   inc_w;

  assign inc_w  = byte_inc(cnt_q);
  assign sum_o  = inc_w[BYTE_W-1:0];
  assign wrap_o = inc_w[BYTE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (load_i) cnt_q <= rdata_i;
      if (commit_i && !hi_pass_i && wrap_o) ovf_q <= 1'b1;
    end
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/stk_inc_addr.sv
module stk_inc_addr
  import stk_inc_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             keep_i,
  input  logic [PTR_W-1:0] sp_i,
  input  step_e            step_i,
  input  logic             cp_idx_i,
  input  logic             hi_pass_i,
  output logic [PTR_W-1:0] addr_o,
  output logic [PTR_W-1:0] sp_o
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);
  localparam logic [PTR_W-1:0] TWO = PTR_W'(2);

  logic [PTR_W-1:0] base_q, wp_q;
  logic [PTR_W-1:0] cp_off, hi_off;

  assign cp_off = cp_idx_i  ? ONE : '0;
  assign hi_off = hi_pass_i ? ONE : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      wp_q   <= '0;
    end else if (accept_i) begin
      base_q <= sp_i;
      wp_q   <= sp_i + PTR_W'(sp_growth(keep_i));
    end
  end

  always_comb begin
    unique case (step_i)
      ST_CP_RD:            addr_o = base_q - TWO + cp_off;
      ST_CP_WR:            addr_o = base_q + cp_off;
      ST_RD, ST_LD, ST_WR: addr_o = wp_q - ONE - hi_off;
      default:             addr_o = wp_q;
    endcase
  end

  assign sp_o = wp_q;
endmodule

// File: rtl/stk_inc_unit.sv
module stk_inc_unit
  import stk_inc_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              keep_i,
  input  logic [PTR_W-1:0]  sp_i,
  output logic [PTR_W-1:0]  ram_addr_o,
  output logic [BYTE_W-1:0] ram_wdata_o,
  output logic              ram_we_o,
  input  logic [BYTE_W-1:0] ram_rdata_i,
  output logic [PTR_W-1:0]  sp_o,
  output logic              done_o
);
  step_e             step_w;
  logic              cp_idx_w, hi_pass_w, accept_w, busy_w;
  logic              wrap_w, ovf_w;
  logic [BYTE_W-1:0] sum_w;
  logic              copy_wr_w, inc_wr_w;

  assign copy_wr_w = (step_w == ST_CP_WR);
  assign inc_wr_w  = (step_w == ST_WR);

  stk_inc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .keep_i    (keep_i),
    .wrap_i    (wrap_w),
    .step_o    (step_w),
    .cp_idx_o  (cp_idx_w),
    .hi_pass_o (hi_pass_w),
    .accept_o  (accept_w),
    .busy_o    (busy_w)
  );

  stk_inc_alu u_alu (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (accept_w),
    .load_i    (step_w == ST_LD),
    .commit_i  (inc_wr_w),
    .hi_pass_i (hi_pass_w),
    .rdata_i   (ram_rdata_i),
    .sum_o     (sum_w),
    .wrap_o    (wrap_w),
    .ovf_o     (ovf_w)
  );

  stk_inc_addr #(.PTR_W(PTR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept_w),
    .keep_i    (keep_i),
    .sp_i      (sp_i),
    .step_i    (step_w),
    .cp_idx_i  (cp_idx_w),
    .hi_pass_i (hi_pass_w),
    .addr_o    (ram_addr_o),
    .sp_o      (sp_o)
  );

  assign ram_we_o    = copy_wr_w || inc_wr_w;
  assign ram_wdata_o = copy_wr_w ? ram_rdata_i : sum_w;
  assign done_o      = (step_w == ST_FIN);
endmodule

// File: rtl/stk_inc_chk.sv
module stk_inc_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             keep_i,
  input logic [PTR_W-1:0] sp_i,
  input logic [PTR_W-1:0] sp_o,
  input logic             ram_we_o,
  input logic             done_o,
  input logic             accept_w,
  input logic             busy_w,
  input logic             hi_pass_w,
  input logic             ovf_w
);
  logic [PTR_W-1:0] exp_sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) exp_sp_q <= '0;
    else if (start_i && !busy_w) exp_sp_q <= keep_i ? sp_i + PTR_W'(2) : sp_i;
  end

  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(ram_we_o));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_hi_pass_on_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_pass_w) |-> ovf_w);
  assert_ovf_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !ovf_w);
  assert_sp_stable_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && $past(busy_w)) |-> $stable(sp_o));
  assert_done_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sp_o == exp_sp_q));
endmodule

bind stk_inc_unit stk_inc_chk #(.PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .keep_i    (keep_i),
  .sp_i      (sp_i),
  .sp_o      (sp_o),
  .ram_we_o  (ram_we_o),
  .done_o    (done_o),
  .accept_w  (accept_w),
  .busy_w    (busy_w),
  .hi_pass_w (hi_pass_w),
  .ovf_w     (ovf_w)
);

// File: tb/test_stk_inc_unit.sv
`timescale 1ns/1ps
module test_stk_inc_unit;
  localparam int PTR_W = 8;
  localparam int DEPTH = 1 << PTR_W;

  typedef struct {
    logic [7:0] sp;
    logic       keep;
    logic [7:0] hi;
    logic [7:0] lo;
    int         start_cyc;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             keep_i = 1'b0;
  logic [PTR_W-1:0] sp_i = '0;
  logic [PTR_W-1:0] ram_addr_o, sp_o;
  logic [7:0]       ram_wdata_o, ram_rdata_i;
  logic             ram_we_o, done_o;

  logic [7:0] mem [DEPTH];
  item_t      sb_q[$];
  int         cyc = 0;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
    ram_rdata_i <= mem[ram_addr_o];
  end

  stk_inc_unit #(.PTR_W(PTR_W)) i_stk_inc_unit (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .keep_i (keep_i),
    .sp_i (sp_i), .ram_addr_o (ram_addr_o), .ram_wdata_o (ram_wdata_o),
    .ram_we_o (ram_we_o), .ram_rdata_i (ram_rdata_i), .sp_o (sp_o),
    .done_o (done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: preload operand and sentinels, queue expectation, pulse start
  task automatic run_op(input logic [7:0] sp, input logic keep,
                        input logic [7:0] hi, input logic [7:0] lo);
    item_t it;
    logic [7:0] wp;
    wp = keep ? sp + 8'd2 : sp;
    @(negedge clk);
    mem[sp - 8'd2] = hi;
    mem[sp - 8'd1] = lo;
    mem[wp]        = 8'h5A;
    mem[sp - 8'd3] = 8'hC3;
    if (keep) mem[sp + 8'd1] = 8'h00;
    it.sp = sp; it.keep = keep; it.hi = hi; it.lo = lo; it.start_cyc = cyc;
    sb_q.push_back(it);
    sp_i = sp; keep_i = keep; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  // monitor: compare each completion against the queued expectation
  initial begin
    logic prev_done;
    prev_done = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && done_o) begin
        if (prev_done) check("R9 done width", 1, 0);
        if (sb_q.size() == 0) begin
          check("R8 unexpected done", 1, 0);
        end else begin
          item_t it;
          logic [15:0] v;
          logic [7:0] wp;
          int carry, lat;
          it = sb_q.pop_front();
          v = {it.hi, it.lo} + 16'd1;
          carry = (it.lo == 8'hFF) ? 1 : 0;
          lat = 4 + 3 * carry + (it.keep ? 4 : 0);
          wp = it.keep ? it.sp + 8'd2 : it.sp;
          check("R2 low byte", mem[wp - 8'd1], v[7:0]);
          check(carry ? "R4 high byte carried" : "R3 high byte kept",
                mem[wp - 8'd2], v[15:8]);
          check("R2/R6/R7 sp_o", sp_o, wp);
          check(carry ? "R4 latency" : "R3 latency", cyc - it.start_cyc, lat);
          check("R5 slot above untouched", mem[wp], 8'h5A);
          check("R5 slot below untouched", mem[it.sp - 8'd3], 8'hC3);
          if (it.keep) begin
            check("R6 original high", mem[it.sp - 8'd2], it.hi);
            check("R6 original low", mem[it.sp - 8'd1], it.lo);
          end
        end
      end
      prev_done = done_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check("watchdog", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 done after reset", done_o, 0);
    check("R1 we after reset", ram_we_o, 0);
    check("R1 sp after reset", sp_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(8'h10, 1'b0, 8'h12, 8'h34);   // R2 R3 plain
    run_op(8'h20, 1'b0, 8'h01, 8'hFF);   // R4 carry
    run_op(8'h30, 1'b0, 8'hFF, 8'hFF);   // R5 full wrap
    run_op(8'h40, 1'b1, 8'h01, 8'hFF);   // R6 keep with carry
    run_op(8'h50, 1'b1, 8'hAB, 8'h10);   // R6 keep no carry
    run_op(8'h01, 1'b0, 8'h7F, 8'hFF);   // R7 operand straddles address 0
    run_op(8'hFF, 1'b1, 8'h00, 8'hFE);   // R7 copy wraps past top
    run_op(8'h00, 1'b0, 8'h00, 8'h00);   // R7 pointer 0

    // R8: second start while busy must be ignored
    for (int a = 8'h9C; a <= 8'hA3; a++) mem[a] = 8'h11;
    fork
      run_op(8'h80, 1'b0, 8'h05, 8'hFF);
      begin
        repeat (3) @(negedge clk);
        sp_i = 8'hA0; keep_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end
    join
    repeat (15) @(negedge clk);
    for (int a = 8'h9C; a <= 8'hA3; a++) check("R8 no write at second pointer", mem[a], 8'h11);
    check("R8 sp_o unchanged", sp_o, 8'h80);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule